// File: doc/BRIEF.md
# Dual-Controller Trigger-Mode Request Latch

This block is the request front end for a pair of cascaded eight-level interrupt controllers, a primary at levels 0-7 and a secondary at levels 8-15. Each level has several raw source lines. The block merges them, detects transitions and keeps one pending-request bit per level. The priority, service and acknowledge logic downstream reads these bits and sends back clear strobes.

Each controller has a trigger-mode byte, written and read through a small byte port. A mode bit of 1 makes its level follow the input. A mode bit of 0 makes the level latch a rising edge until the request is acknowledged. Some levels are fixed to edge mode by masks applied on write. A controller that is not yet initialized ignores its inputs. An initialization strobe empties all of that controller's pending bits.

Top module: `trig_req_latch`

## Requirements
- R1: After synchronous reset, `req_out` is all zero and both mode bytes read back as zero.
- R2: A write with `cfg_sel`=0 stores `cfg_wdata & 8'hF8` as the primary mode byte, so levels 0, 1 and 2 always stay edge mode. A write with `cfg_sel`=1 stores `cfg_wdata & 8'hDE` as the secondary byte, so levels 8 and 13 always stay edge mode. `cfg_rdata` shows the stored byte selected by `cfg_sel` in the same cycle. Bit k of byte c sets the mode of level 8c+k (1 = level, 0 = edge).
- R3: On a ready controller, a 0-to-1 change of a level's merged input sets `req_out` for that level at the next clock edge, in either mode.
- R4: In edge mode a 1-to-0 change leaves the request set. A one-cycle pulse leaves exactly one pending request.
- R5: In level mode the request is set on every cycle the merged input is high, and a 1-to-0 change clears it.
- R6: The merged input of level L is the OR of `src_in[2L]` and `src_in[2L+1]`. Edges are found by comparing it with a registered copy from the previous cycle.
- R7: While a controller's `ctrl_ready` bit is low, input changes on its levels neither set nor clear requests.
- R8: An `ack_clr` strobe clears its level's request only if that level's merged input is low in that cycle. Otherwise it has no effect.
- R9: An `init_clr` strobe clears all eight requests of its controller at the next edge. It overrides any set that arrives in the same cycle and leaves the other controller untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 32 | Raw source lines, two per level (level L uses bits 2L and 2L+1) |
| ctrl_ready | input | 2 | Per-controller initialized flag (bit 0 primary, bit 1 secondary) |
| init_clr | input | 2 | Per-controller strobe clearing all of its requests |
| ack_clr | input | 16 | Per-level acknowledge clear strobe |
| cfg_wr | input | 1 | Mode byte write enable |
| cfg_sel | input | 1 | Mode byte select for write and read (0 primary, 1 secondary) |
| cfg_wdata | input | 8 | Mode byte write data |
| cfg_rdata | output | 8 | Selected mode byte |
| req_out | output | 16 | Pending request bits, one per level |

## Verification
Two pairs of events can land on the same clock edge. The first is an acknowledge strobe arriving while its level's input is still high. The bench raises an input and pulses `ack_clr` on that level one cycle later, in edge mode and in level mode. It expects the request to survive in both cases and to clear only once the input has dropped. The second is an initialization strobe arriving together with a fresh rising edge on one of its levels. The bench judges this by requiring that controller's bits to be empty while the other controller's pending bit stays set.

// File: rtl/trig_latch_pkg.sv
package trig_latch_pkg;

    localparam int CTRLS         = 2;
    localparam int LVLS_PER_CTRL = 8;
    localparam int SRCS_PER_LVL  = 2;

    // Per-level view of the merged input after transition detection
    typedef struct packed {
        logic now;
        logic rise;
        logic fall;
    } pin_evt_t;

    // Write mask: zero bits are levels fixed to edge mode
    function automatic logic [LVLS_PER_CTRL-1:0] lock_mask(input int unsigned ctrl);
        logic [LVLS_PER_CTRL-1:0] m;
        m = '1;
        if (ctrl == 0) begin
            for (int k = 0; k < 3 && k < LVLS_PER_CTRL; k++) m[k] = 1'b0;
        end else begin
            m[0] = 1'b0;
            if (LVLS_PER_CTRL > 5) m[5] = 1'b0;
        end
        return m;
    endfunction

endpackage

// File: rtl/trig_mode_regs.sv
module trig_mode_regs
    import trig_latch_pkg::*;
#(
    parameter int NUM_CTRL = CTRLS,
    parameter int LVL_W    = LVLS_PER_CTRL,
    localparam int SEL_W   = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1,
    localparam int NLVL    = NUM_CTRL * LVL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] sel,
    input  logic [LVL_W-1:0] wr_data,
    output logic [LVL_W-1:0] rd_data,
    output logic [NLVL-1:0]  mode_bits
);

    logic [LVL_W-1:0] mode_q [NUM_CTRL];

    for (genvar c = 0; c < NUM_CTRL; c++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                mode_q[c] <= '0;
            end else if (wr_en && sel == SEL_W'(c)) begin
                mode_q[c] <= wr_data & lock_mask(c);
            end
        end
        assign mode_bits[c*LVL_W +: LVL_W] = mode_q[c];
    end

    assign rd_data = mode_q[sel];

endmodule

// File: rtl/trig_pin_sense.sv
module trig_pin_sense
    import trig_latch_pkg::*;
#(
    parameter int NSRC = SRCS_PER_LVL
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src,
    output pin_evt_t        evt
);

    logic merged;
    logic prev_q;

    assign merged = |src;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= merged;
    end

    always_comb begin
        evt.now  = merged;
        evt.rise = merged & ~prev_q;
        evt.fall = ~merged & prev_q;
    end

endmodule

// File: rtl/trig_req_cell.sv
module trig_req_cell
    import trig_latch_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ready,
    input  logic     level_mode,
    input  logic     init_clr,
    input  logic     ack_clr,
    input  pin_evt_t evt,
    output logic     req
);

    logic set_c;
    logic drop_c;
    logic req_nxt;

    always_comb begin
        set_c  = ready & (evt.rise | (level_mode & evt.now));
        drop_c = (ready & level_mode & evt.fall) | (ack_clr & ~evt.now);
        if (init_clr) req_nxt = 1'b0;
        else          req_nxt = (req | set_c) & ~drop_c;
    end

    always_ff @(posedge clk) begin
        if (rst) req <= 1'b0;
        else     req <= req_nxt;
    end

    assert_init_empties_R9: assert property (@(posedge clk) disable iff (rst)
        init_clr |=> !req);

    assert_rise_sets_R3: assert property (@(posedge clk) disable iff (rst)
        ready && evt.rise && !init_clr |=> req);

    assert_level_high_sets_R5: assert property (@(posedge clk) disable iff (rst)
        ready && level_mode && evt.now && !init_clr |=> req);

    assert_edge_keeps_R4: assert property (@(posedge clk) disable iff (rst)
        !level_mode && req && !ack_clr && !init_clr |=> req);

    assert_idle_no_set_R7: assert property (@(posedge clk) disable iff (rst)
        !ready && !req |=> !req);

    assert_ack_needs_low_R8: assert property (@(posedge clk) disable iff (rst)
        req && ack_clr && evt.now && !init_clr |=> req);

endmodule

// File: rtl/trig_req_latch.sv
module trig_req_latch
    import trig_latch_pkg::*;
#(
    parameter int NUM_CTRL = CTRLS,
    parameter int LVL_W    = LVLS_PER_CTRL,
    parameter int NSRC     = SRCS_PER_LVL,
    localparam int SEL_W   = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1,
    localparam int NLVL    = NUM_CTRL * LVL_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NLVL*NSRC-1:0] src_in,
    input  logic [NUM_CTRL-1:0]  ctrl_ready,
    input  logic [NUM_CTRL-1:0]  init_clr,
    input  logic [NLVL-1:0]      ack_clr,
    input  logic                 cfg_wr,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [LVL_W-1:0]     cfg_wdata,
    output logic [LVL_W-1:0]     cfg_rdata,
    output logic [NLVL-1:0]      req_out
);

    logic [NLVL-1:0] mode_bits;

    trig_mode_regs #(
        .NUM_CTRL (NUM_CTRL),
        .LVL_W    (LVL_W)
    ) u_modes (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_wr),
        .sel       (cfg_sel),
        .wr_data   (cfg_wdata),
        .rd_data   (cfg_rdata),
        .mode_bits (mode_bits)
    );

    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        localparam int CI = g / LVL_W;
        pin_evt_t evt;

        trig_pin_sense #(.NSRC(NSRC)) u_sense (
            .clk (clk),
            .rst (rst),
            .src (src_in[g*NSRC +: NSRC]),
            .evt (evt)
        );

        trig_req_cell u_cell (
            .clk        (clk),
            .rst        (rst),
            .ready      (ctrl_ready[CI]),
            .level_mode (mode_bits[g]),
            .init_clr   (init_clr[CI]),
            .ack_clr    (ack_clr[g]),
            .evt        (evt),
            .req        (req_out[g])
        );
    end

endmodule

// File: tb/trig_req_latch_bench.sv
`timescale 1ns/1ps
module trig_req_latch_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] src_in;
    logic [1:0]  ctrl_ready;
    logic [1:0]  init_clr;
    logic [15:0] ack_clr;
    logic        cfg_wr;
    logic [0:0]  cfg_sel;
    logic [7:0]  cfg_wdata;
    logic [7:0]  cfg_rdata;
    logic [15:0] req_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    trig_req_latch u_trig_req_latch (
        .clk(clk), .rst(rst), .src_in(src_in), .ctrl_ready(ctrl_ready),
        .init_clr(init_clr), .ack_clr(ack_clr), .cfg_wr(cfg_wr),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_out(req_out)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic sel, input logic [7:0] d);
        cfg_sel = sel; cfg_wdata = d; cfg_wr = 1'b1;
        tick();
        cfg_wr = 1'b0;
    endtask

    function automatic logic lvl_allowed(input int i);
        logic [7:0] m;
        m = (i < 8) ? 8'hF8 : 8'hDE;
        return m[i % 8];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; src_in = '0; ctrl_ready = 2'b11; init_clr = '0;
        ack_clr = '0; cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        check("R1 req", req_out, 16'h0);
        cfg_sel = 1'b0; #1 check("R1 mode0", {8'h0, cfg_rdata}, 16'h0);
        cfg_sel = 1'b1; #1 check("R1 mode1", {8'h0, cfg_rdata}, 16'h0);

        // R2 exhaustive mode byte writes with masks
        for (int s = 0; s < 2; s++) begin
            for (int v = 0; v < 256; v++) begin
                write_cfg(s[0], v[7:0]);
                check("R2 readback", {8'h0, cfg_rdata},
                      {8'h0, v[7:0] & ((s == 0) ? 8'hF8 : 8'hDE)});
            end
        end

        // R3 R4 R5 R6 R8 sweep: every level, every source, both configs
        for (int cfg = 0; cfg < 2; cfg++) begin
            write_cfg(1'b0, cfg ? 8'hFF : 8'h00);
            write_cfg(1'b1, cfg ? 8'hFF : 8'h00);
            for (int i = 0; i < 16; i++) begin
                for (int s = 0; s < 2; s++) begin
                    logic lvl;
                    lvl = (cfg == 1) && lvl_allowed(i);
                    src_in[i*2+s] = 1'b1;
                    tick();
                    check("R3 R6 rise sets", req_out, 16'h1 << i);
                    src_in[i*2+s] = 1'b0;
                    tick();
                    if (lvl) begin
                        check("R5 fall clears", req_out, 16'h0);
                    end else begin
                        check("R4 fall keeps", req_out, 16'h1 << i);
                        ack_clr[i] = 1'b1;
                        tick();
                        ack_clr[i] = 1'b0;
                        check("R8 ack clears", req_out, 16'h0);
                    end
                end
            end
        end

        // R8 edge mode: ack while input high is ignored
        write_cfg(1'b0, 8'h00);
        write_cfg(1'b1, 8'h00);
        src_in[8] = 1'b1; tick();
        ack_clr[4] = 1'b1; tick(); ack_clr[4] = 1'b0;
        check("R8 ack ignored high edge", req_out, 16'h0010);
        src_in[8] = 1'b0; tick();
        check("R4 kept after fall", req_out, 16'h0010);
        ack_clr[4] = 1'b1; tick(); ack_clr[4] = 1'b0;
        check("R8 ack clears low", req_out, 16'h0);

        // R4 single-cycle pulse on level 9
        src_in[19] = 1'b1; tick();
        src_in[19] = 1'b0; tick(); tick();
        check("R4 pulse one request", req_out, 16'h0200);
        ack_clr[9] = 1'b1; tick(); ack_clr[9] = 1'b0;

        // R5 level mode: ack while high ignored, held high stays set
        write_cfg(1'b0, 8'hFF);
        write_cfg(1'b1, 8'hFF);
        src_in[10] = 1'b1; tick();
        ack_clr[5] = 1'b1; tick(); ack_clr[5] = 1'b0;
        check("R5 R8 level ack while high", req_out, 16'h0020);
        tick();
        check("R5 level held", req_out, 16'h0020);
        src_in[10] = 1'b0; tick();
        check("R5 level drop", req_out, 16'h0);

        // R7 not-ready controller ignores changes
        ctrl_ready = 2'b01;
        write_cfg(1'b1, 8'h00);
        src_in[20] = 1'b1; tick(); tick();
        check("R7 secondary idle no set", req_out, 16'h0);
        src_in[20] = 1'b0; tick();
        ctrl_ready = 2'b11;
        write_cfg(1'b1, 8'hFF);
        src_in[24] = 1'b1; tick();
        check("R5 level 12 set", req_out, 16'h1000);
        ctrl_ready = 2'b01;
        src_in[24] = 1'b0; tick();
        check("R7 fall ignored idle", req_out, 16'h1000);
        ctrl_ready = 2'b11; tick();
        check("R7 still held after ready", req_out, 16'h1000);
        ack_clr[12] = 1'b1; tick(); ack_clr[12] = 1'b0;
        check("R8 ack clears level 12", req_out, 16'h0);
        ctrl_ready = 2'b10;
        src_in[6] = 1'b1; tick(); tick();
        check("R7 primary idle level high", req_out, 16'h0);
        src_in[6] = 1'b0; ctrl_ready = 2'b11; tick();

        // R9 init clears own controller, beats same-cycle rise
        write_cfg(1'b0, 8'h00);
        write_cfg(1'b1, 8'h00);
        src_in[2] = 1'b1; src_in[18] = 1'b1; tick();
        src_in[2] = 1'b0; src_in[18] = 1'b0; tick();
        check("R9 setup", req_out, 16'h0202);
        init_clr = 2'b01; src_in[4] = 1'b1; tick(); init_clr = 2'b00;
        check("R9 primary cleared, secondary kept", req_out, 16'h0200);
        src_in[4] = 1'b0;
        init_clr = 2'b10; tick(); init_clr = 2'b00;
        check("R9 secondary cleared", req_out, 16'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule